// File: doc/BRIEF.md
# Flip-flop byte-writable RAM

A single-port memory of 256 words by 32 bits built from ordinary flip-flops, meant for places where a compiled macro is unavailable or too coarse. A write stores any subset of the four byte lanes of the addressed word on a rising clock edge. A read returns the word whose address was presented one cycle earlier.

The address is turned into a one-hot word select in stages. Bit pairs are decoded first, the pair decodes are merged into two 16-way decodes, and those are merged into 256 selects. Each byte lane of each word gets its own write strobe, which is the product of the word select, chip enable and that lane's write enable. On the read side the one-hot select is registered. Each stored word is gated by its registered select bit, and the gated words pass through a binary tree whose levels alternate NAND and NOR, so the whole tree computes an OR of the gated words. A final gate drives the output to zero while reset is high. Reset does not touch the stored contents. The block has plain control pins with no handshake: it accepts an access every cycle and never stalls.

Top module: `ffram_top`

## Requirements
- R1: A word read returns, in the cycle after its address is presented, the 32 bits most recently stored at that address (one cycle of read latency), for every address 0 to 255.
- R2: Byte lane k is write-data bits 8k to 8k+7 and is controlled by write-enable bit k. A lane is stored on a rising edge only when chip enable and that lane's enable are both high.
- R3: Lanes whose write enable is low keep their previous contents during a write to other lanes of the same word.
- R4: With chip enable low, nothing is stored, whatever the write enables and write data are.
- R5: A read of a word in the cycle after a write to it returns the newly written bytes merged with the unwritten ones.
- R6: The read select is captured on every rising edge whether or not chip enable is high, so reads work with chip enable low.
- R7: While reset is high the read data output is all zeros.
- R8: Reset leaves the stored contents unchanged. After reset is released, reads return the data held before reset.
- R9: The decoded word select has exactly one bit set for any address, and the registered select equals the decoded select of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Active-high reset; forces the read output to zero |
| ce | input | 1 | Chip enable; gates every write strobe |
| addr | input | 8 | Word address for both write and read |
| we | input | 4 | Per-lane write enables, bit k for data bits 8k to 8k+7 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the address of the previous cycle |

## Verification
The assertions check on every cycle that the decoded select is one-hot, that the registered select follows it by one cycle, and that the output is zero during reset. They also check that every enabled lane reads back the written byte in the next cycle, and that the output holds steady when the same word is read again with no write. Only the bench's scenarios can show that ignored writes (chip enable low, or lane enables clear) leave the stored data unchanged at other times. The same holds for the full 256-address sweep proving each word is distinct, and for the contents surviving a reset pulse, because these need a model of the whole array.

// File: rtl/ffram_pkg.sv
package ffram_pkg;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 32;
  parameter int LANE_W = 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / LANE_W;
endpackage

// File: rtl/ffram_decode.sv
module ffram_decode #(
  parameter int AW = ffram_pkg::ADDR_W,
  localparam int N = 1 << AW
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  sel
);
  generate
    if (AW == 8) begin : g_tiered
      // stage 1: each address bit pair to four lines
      logic [3:0]  pair_dec [4];
      // stage 2: two pair decodes to sixteen lines
      logic [15:0] quad_dec [2];
      for (genvar g = 0; g < 4; g++) begin : g_pair
        for (genvar v = 0; v < 4; v++) begin : g_val
          assign pair_dec[g][v] = (addr[2*g +: 2] == 2'(v));
        end
      end
      for (genvar h = 0; h < 2; h++) begin : g_quad
        for (genvar i = 0; i < 16; i++) begin : g_line
          assign quad_dec[h][i] = pair_dec[2*h][i % 4] & pair_dec[2*h+1][i / 4];
        end
      end
      for (genvar w = 0; w < N; w++) begin : g_word
        assign sel[w] = quad_dec[0][w % 16] & quad_dec[1][w / 16];
      end
    end else begin : g_flat
      for (genvar w = 0; w < N; w++) begin : g_word
        assign sel[w] = (addr == AW'(w));
      end
    end
  endgenerate
endmodule

// File: rtl/ffram_store.sv
module ffram_store #(
  parameter int AW = ffram_pkg::ADDR_W,
  parameter int DW = ffram_pkg::DATA_W,
  parameter int LW = ffram_pkg::LANE_W,
  localparam int N  = 1 << AW,
  localparam int NL = DW / LW
) (
  input  logic          clk,
  input  logic [N-1:0]  sel,
  input  logic          ce,
  input  logic [NL-1:0] we,
  input  logic [DW-1:0] wdata,
  output logic [N*DW-1:0] words
);
  generate
    for (genvar w = 0; w < N; w++) begin : g_word
      for (genvar k = 0; k < NL; k++) begin : g_lane
        logic strobe;
        assign strobe = sel[w] & ce & we[k];
        always_ff @(posedge clk) begin
          if (strobe) words[w*DW + k*LW +: LW] <= wdata[k*LW +: LW];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ffram_rdtree.sv
module ffram_rdtree #(
  parameter int AW = ffram_pkg::ADDR_W,
  parameter int DW = ffram_pkg::DATA_W,
  localparam int N = 1 << AW,
  localparam int NODES = 2*N - 1
) (
  input  logic [N-1:0]    sel_q,
  input  logic [N*DW-1:0] words,
  output logic [DW-1:0]   merged
);
  // heap layout: node 0 is the root, node n has children 2n+1 and 2n+2,
  // leaves occupy N-1 .. 2N-2. A node at depth d holds its true value
  // when (AW-d) is odd and the inverted value when it is even.
  logic [DW-1:0] node [NODES];

  generate
    for (genvar w = 0; w < N; w++) begin : g_leaf
      assign node[N-1+w] = ~(words[w*DW +: DW] & {DW{sel_q[w]}});
    end
    for (genvar d = 0; d < AW; d++) begin : g_depth
      for (genvar j = 0; j < (1 << d); j++) begin : g_node
        localparam int IDX = (1 << d) - 1 + j;
        if ((AW - d) % 2 == 1) begin : g_nand
          assign node[IDX] = ~(node[2*IDX+1] & node[2*IDX+2]);
        end else begin : g_nor
          assign node[IDX] = ~(node[2*IDX+1] | node[2*IDX+2]);
        end
      end
    end
    if (AW % 2 == 1) begin : g_true_root
      assign merged = node[0];
    end else begin : g_inv_root
      assign merged = ~node[0];
    end
  endgenerate
endmodule

// File: rtl/ffram_top.sv
module ffram_top #(
  parameter int AW = ffram_pkg::ADDR_W,
  parameter int DW = ffram_pkg::DATA_W,
  parameter int LW = ffram_pkg::LANE_W,
  localparam int N  = 1 << AW,
  localparam int NL = DW / LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [N-1:0]    sel;
  logic [N-1:0]    sel_q;
  logic [N*DW-1:0] words;
  logic [DW-1:0]   merged;

  ffram_decode #(.AW(AW)) u_dec (.addr(addr), .sel(sel));

  ffram_store #(.AW(AW), .DW(DW), .LW(LW)) u_store (
    .clk(clk), .sel(sel), .ce(ce), .we(we), .wdata(wdata), .words(words)
  );

  // read select loads every cycle, independent of ce and rst
  always_ff @(posedge clk) sel_q <= sel;

  ffram_rdtree #(.AW(AW), .DW(DW)) u_tree (
    .sel_q(sel_q), .words(words), .merged(merged)
  );

  assign rdata = merged & ~{DW{rst}};
endmodule

// File: rtl/ffram_chk.sv
module ffram_chk #(
  parameter int AW = ffram_pkg::ADDR_W,
  parameter int DW = ffram_pkg::DATA_W,
  parameter int LW = ffram_pkg::LANE_W,
  localparam int N  = 1 << AW,
  localparam int NL = DW / LW
) (
  input logic          clk,
  input logic          rst,
  input logic          ce,
  input logic [NL-1:0] we,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [N-1:0]  sel,
  input logic [N-1:0]  sel_q
);
  // R7
  reset_zero_chk: assert property (@(posedge clk) rst |-> (rdata == '0));

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1);

  // R9
  sel_reg_chk: assert property (@(posedge clk) disable iff (rst)
    sel_q == $past(sel));

  // R4
  reread_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!(ce && (|we)) && (sel_q == sel)) |=> $stable(rdata));

  generate
    for (genvar k = 0; k < NL; k++) begin : g_lane
      // R5
      lane_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && we[k]) |=> (rdata[k*LW +: LW] == $past(wdata[k*LW +: LW])));
    end
  endgenerate
endmodule

bind ffram_top ffram_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .we(we), .wdata(wdata), .rdata(rdata),
  .sel(sel), .sel_q(sel_q)
);

// File: tb/ffram_top_tb.sv
module ffram_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  we = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] shadow [256];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  ffram_top u_dut (.clk(clk), .rst(rst), .ce(ce), .addr(addr), .we(we),
                   .wdata(wdata), .rdata(rdata));

  always #5 clk = ~clk;

  // fields: ce, we, addr, wdata, expected read
  localparam logic [76:0] VEC [8] = '{
    {1'b1, 4'hF, 8'h10, 32'h11223344, 32'h11223344},
    {1'b1, 4'h1, 8'h10, 32'hAABBCCDD, 32'h112233DD},
    {1'b1, 4'h4, 8'h10, 32'h55667788, 32'h116633DD},
    {1'b0, 4'hF, 8'h10, 32'hFFFFFFFF, 32'h116633DD},
    {1'b1, 4'h0, 8'h10, 32'h00000000, 32'h116633DD},
    {1'b1, 4'h8, 8'hFF, 32'hA5000000, 32'hA500A500},
    {1'b1, 4'h2, 8'h00, 32'h0000BE00, 32'h00FFBE01},
    {1'b0, 4'h0, 8'h10, 32'h00000000, 32'h116633DD}
  };

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, a + 8'd1};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%08h expected=%08h", req, got, exp);
    end
  endtask

  // called just after a falling edge; returns rdata sampled 1 ns after the next rising edge
  task automatic step(input logic c, input logic [3:0] w, input logic [7:0] a,
                      input logic [31:0] d, output logic [31:0] r);
    ce = c; we = w; addr = a; wdata = d;
    @(posedge clk);
    if (c) begin
      for (int k = 0; k < 4; k++)
        if (w[k]) shadow[a][8*k +: 8] = d[8*k +: 8];
    end
    #1 r = rdata;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: rdata=%08h expected=completion", rdata);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 check("R7 initial reset", rdata, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // fill every word, reading back the next cycle
    for (int a = 0; a < 256; a++) begin
      step(1'b1, 4'hF, 8'(a), pat(8'(a)), r);
      check("R1 R5 fill", r, pat(8'(a)));
    end
    // read every word with ce low: distinct contents prove unique selects
    for (int a = 255; a >= 0; a--) begin
      step(1'b0, 4'h0, 8'(a), 32'hDEADBEEF, r);
      check("R1 R6 R9 sweep", r, pat(8'(a)));
    end

    // vector table: lane masks, ce-low writes, empty masks
    for (int i = 0; i < 8; i++) begin
      step(VEC[i][76], VEC[i][75:72], VEC[i][71:64], VEC[i][63:32], r);
      check("R2 R3 R4 vector", r, VEC[i][31:0]);
    end

    // ce low with all lanes enabled, then read back on a different word
    step(1'b0, 4'hF, 8'h20, 32'h0, r);
    step(1'b0, 4'h0, 8'h21, 32'h0, r);
    step(1'b0, 4'h0, 8'h20, 32'h0, r);
    check("R4 ce low ignored", r, pat(8'h20));

    // back-to-back writes to adjacent words
    step(1'b1, 4'h3, 8'h7F, 32'h0000CAFE, r);
    check("R5 write 7F", r, shadow[8'h7F]);
    step(1'b1, 4'hC, 8'h80, 32'hBEEF0000, r);
    check("R5 write 80", r, shadow[8'h80]);
    step(1'b0, 4'h0, 8'h7F, 32'h0, r);
    check("R3 lanes kept 7F", r, 32'h7F80CAFE);

    // reset pulse: output zero during reset, contents survive it
    rst = 1'b1;
    step(1'b0, 4'h0, 8'h10, 32'h0, r);
    check("R7 reset zero", r, 32'h0);
    step(1'b0, 4'h0, 8'hFF, 32'h0, r);
    check("R7 reset zero", r, 32'h0);
    rst = 1'b0;
    #1 check("R8 output after release", rdata, 32'hA500A500);
    step(1'b0, 4'h0, 8'h10, 32'h0, r);
    check("R8 contents kept", r, 32'h116633DD);
    step(1'b0, 4'h0, 8'h80, 32'h0, r);
    check("R8 contents kept", r, shadow[8'h80]);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule